// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches the pins of a general-purpose I/O port of up to eight lines and turns selected signal transitions into interrupts. Each pin is brought into the clock domain through a two-stage synchronizer. A third stage holds the previous synchronized level, and comparing the two stages reveals a transition. A per-pin polarity bit chooses whether a rising or a falling transition counts as active. An active transition latches a sticky per-pin flag. Each flag is gated by a per-pin enable, and the gated terms are ORed together into a single registered interrupt request.

Software uses a small register port to read and write the enable, polarity and flag registers. A flag is cleared by writing 1 to its bit. The block has no direction input: the pad level is sampled whether the pin drives or receives. A reduced build implements only the low pins; its upper bits read as zero and do not respond to writes.

A small arming state machine keeps the synchronizer contents that exist right after reset from being taken as transitions. It starts in FILL_A on reset and steps FILL_A -> FILL_B -> FILL_C -> LIVE, one state per clock. It stays in LIVE until the next reset. Flags can only set while the machine is in LIVE.

Top module: `pin_edge_irq`

## Requirements
- R1: The register port decodes reg_addr as follows: 0 = enable, 1 = polarity, 2 = flag, 3 = unused. Address 3 reads 0 and ignores writes. reg_rdata shows the addressed register combinationally, and a write takes effect at the clock edge where reg_we is 1.
- R2: After reset, the enable and flag registers are all 0, the polarity register is all 1 on implemented pins, and irq_o is 0.
- R3: A transition on pin i sets flag bit i at the third rising clock edge after the change, if it matches polarity bit i (1 = rising, 0 = falling). A transition of the opposite direction sets no flag.
- R4: Writing the flag register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A flag latches on an active transition even when its enable bit is 0, and irq_o stays 0 in that case.
- R6: irq_o equals the OR over all pins of (flag AND enable), delayed by one clock edge.
- R7: If an active transition and a write of 1 hit the same flag bit in the same cycle, the flag ends at 1.
- R8: Changing polarity bits while the pins are steady never sets a flag.
- R9: Pin levels present at reset release are not taken as transitions. No flag sets during the three clock edges that follow reset release.
- R10: In a reduced build with IMPL_PINS below NUM_PINS, the enable, polarity and flag bits at and above IMPL_PINS read 0, ignore writes, and never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Pad levels of the port pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data of the selected register |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
A wrong synchronizer or history bit shows up in the flag register. It appears as a missing flag, a flag from the wrong direction, or a flag that sets one edge early or late, and each of these is visible on a read the cycle after the third edge following a pin change. A flag register that ignores write-one-to-clear, or that lets a clear win over a simultaneous set, shows on the read right after the write. A wrong gating or register stage on the request shows on irq_o one edge after a flag or enable changes. An arming machine that goes live too early shows as flags set after reset release with the pins held high.

// File: rtl/pei_pkg.sv
package pei_pkg;

    typedef enum logic [1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_FLAG     = 2'd2,
        REG_NONE     = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ARM_FILL_A = 2'd0,
        ARM_FILL_B = 2'd1,
        ARM_FILL_C = 2'd2,
        ARM_LIVE   = 2'd3
    } arm_state_e;

endpackage

// File: rtl/pei_arm_fsm.sv
module pei_arm_fsm
    import pei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic armed_o
);

    arm_state_e state_q;
    arm_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_FILL_A;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_FILL_A: state_d = ARM_FILL_B;
            ARM_FILL_B: state_d = ARM_FILL_C;
            ARM_FILL_C: state_d = ARM_LIVE;
            ARM_LIVE:   state_d = ARM_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        armed_o = 1'b0;
        unique case (state_q)
            ARM_FILL_A, ARM_FILL_B, ARM_FILL_C: armed_o = 1'b0;
            ARM_LIVE:                           armed_o = 1'b1;
        endcase
    end

    // R9
    live_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_LIVE) |=> (state_q == ARM_LIVE));

    // R9
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_FILL_A) |=> (state_q == ARM_FILL_B));

endmodule

// File: rtl/pei_edge.sv
module pei_edge #(
    parameter int NUM_PINS  = 8,
    parameter int IMPL_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] pol_i,
    input  logic                armed_i,
    output logic [NUM_PINS-1:0] set_o
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        if (g < IMPL_PINS) begin : g_live
            logic meta_q;
            logic level_q;
            logic hist_q;
            logic rose;
            logic fell;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q  <= 1'b0;
                    level_q <= 1'b0;
                    hist_q  <= 1'b0;
                end else begin
                    meta_q  <= pin_i[g];
                    level_q <= meta_q;
                    hist_q  <= level_q;
                end
            end

            // history follows the raw level, so polarity has no memory
            assign rose     = level_q & ~hist_q;
            assign fell     = ~level_q & hist_q;
            assign set_o[g] = armed_i & (pol_i[g] ? rose : fell);

            // R8
            pol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($changed(pol_i[g]) && $stable(level_q)) |-> !set_o[g]);
        end else begin : g_absent
            logic unused_pin;
            assign unused_pin = pin_i[g] ^ pol_i[g];
            assign set_o[g]   = 1'b0;
        end
    end

endmodule

// File: rtl/pei_regs.sv
module pei_regs
    import pei_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    parameter int IMPL_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [1:0]          addr_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    input  logic [NUM_PINS-1:0] set_i,
    output logic [NUM_PINS-1:0] rdata_o,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] flag_o
);

    localparam logic [NUM_PINS-1:0] IMPL_MASK =
        {NUM_PINS{1'b1}} >> (NUM_PINS - IMPL_PINS);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] flag_q;
    logic [NUM_PINS-1:0] clr;

    assign sel = reg_sel_e'(addr_i);
    assign clr = (we_i && sel == REG_FLAG) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= IMPL_MASK;
            flag_q <= '0;
        end else begin
            if (we_i && sel == REG_ENABLE)   en_q  <= wdata_i & IMPL_MASK;
            if (we_i && sel == REG_POLARITY) pol_q <= wdata_i & IMPL_MASK;
            // set wins over a simultaneous clear
            flag_q <= ((flag_q & ~clr) | set_i) & IMPL_MASK;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_ENABLE:   rdata_o = en_q;
            REG_POLARITY: rdata_o = pol_q;
            REG_FLAG:     rdata_o = flag_q;
            REG_NONE:     rdata_o = '0;
        endcase
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign flag_o = flag_q;

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == REG_FLAG) |=> ((flag_q & $past(wdata_i) & ~$past(set_i)) == '0));

    // R4
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == REG_FLAG) |=> (($past(flag_q) & ~$past(wdata_i) & ~flag_q) == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R3
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_o & ~IMPL_MASK) == '0));

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
    parameter int NUM_PINS  = 8,
    parameter int IMPL_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic                irq_o
);

    logic                armed;
    logic [NUM_PINS-1:0] set_w;
    logic [NUM_PINS-1:0] en_w;
    logic [NUM_PINS-1:0] pol_w;
    logic [NUM_PINS-1:0] flag_w;
    logic                irq_q;

    pei_arm_fsm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_o (armed)
    );

    pei_edge #(
        .NUM_PINS  (NUM_PINS),
        .IMPL_PINS (IMPL_PINS)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .pol_i   (pol_w),
        .armed_i (armed),
        .set_o   (set_w)
    );

    pei_regs #(
        .NUM_PINS  (NUM_PINS),
        .IMPL_PINS (IMPL_PINS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .set_i   (set_w),
        .rdata_o (reg_rdata),
        .en_o    (en_w),
        .pol_o   (pol_w),
        .flag_o  (flag_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(flag_w & en_w);
        end
    end

    assign irq_o = irq_q;

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|flag_w));

    // R9
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (flag_w == '0));

endmodule

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pins;
    logic       we;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata0;
    logic [7:0] rdata1;
    logic       irq0;
    logic       irq1;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    pin_edge_irq #(.NUM_PINS(8), .IMPL_PINS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata0), .irq_o(irq0));

    pin_edge_irq #(.NUM_PINS(8), .IMPL_PINS(4)) u1 (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata1), .irq_o(irq1));

    localparam logic [1:0] A_EN = 2'd0, A_POL = 2'd1, A_FLAG = 2'd2, A_NONE = 2'd3;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d0, output logic [7:0] d1);
        addr = a;
        #1;
        d0 = rdata0;
        d1 = rdata1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v0, v1;
        rst_n = 1'b0; pins = 8'hFF; we = 1'b0; addr = 2'd0; wdata = 8'h00;
        step(3);
        rst_n = 1'b1;

        // R2 reset state
        rd(A_EN, v0, v1);   chk("R2 enable", v0, 8'h00); chk("R2 enable u1", v1, 8'h00);
        rd(A_POL, v0, v1);  chk("R2 polarity", v0, 8'hFF); chk("R2 polarity u1", v1, 8'h0F);
        rd(A_FLAG, v0, v1); chk("R2 flag", v0, 8'h00);
        chk("R2 irq", {7'd0, irq0}, 8'h00);

        // R9 pins high through reset, rising polarity: no flag
        step(8);
        rd(A_FLAG, v0, v1); chk("R9 warmup u0", v0, 8'h00); chk("R9 warmup u1", v1, 8'h00);

        // R1 unused address
        wr(A_NONE, 8'hFF);
        rd(A_NONE, v0, v1); chk("R1 addr3 reads 0", v0, 8'h00);
        rd(A_EN, v0, v1);   chk("R1 addr3 write ignored", v0, 8'h00);
        rd(A_POL, v0, v1);  chk("R1 addr3 polarity kept", v0, 8'hFF);

        // R10 reduced build register masking
        wr(A_EN, 8'hFF);  rd(A_EN, v0, v1);  chk("R10 enable u1", v1, 8'h0F); chk("R1 enable u0", v0, 8'hFF);
        wr(A_POL, 8'hA5); rd(A_POL, v0, v1); chk("R10 polarity u1", v1, 8'h05); chk("R1 polarity u0", v0, 8'hA5);
        wr(A_EN, 8'h00);

        // R3 R4 R5 R6 exhaustive sweep over pin, polarity, direction
        for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [7:0] exp;
                    exp = (pol == dir) ? (8'h01 << p) : 8'h00;
                    wr(A_EN, 8'h00);
                    wr(A_POL, pol ? (8'h01 << p) : 8'h00);
                    pins = dir ? 8'h00 : 8'hFF;
                    step(5);
                    wr(A_FLAG, 8'hFF);
                    pins[p] = dir[0];
                    step(2);
                    rd(A_FLAG, v0, v1); chk($sformatf("R3 latency pin%0d", p), v0, 8'h00);
                    step(1);
                    rd(A_FLAG, v0, v1); chk($sformatf("R3 flag pin%0d pol%0d dir%0d", p, pol, dir), v0, exp);
                    chk("R10 flag u1", v1, exp & 8'h0F);
                    step(1);
                    chk("R5 masked irq", {7'd0, irq0}, 8'h00);
                    wr(A_FLAG, 8'h00);
                    rd(A_FLAG, v0, v1); chk("R4 zero write keeps", v0, exp);
                    wr(A_EN, 8'hFF);
                    step(1);
                    chk("R6 irq on enable", {7'd0, irq0}, {7'd0, |exp});
                    wr(A_FLAG, 8'h01 << p);
                    rd(A_FLAG, v0, v1); chk("R4 one write clears", v0, 8'h00);
                    step(1);
                    chk("R6 irq after clear", {7'd0, irq0}, 8'h00);
                end
            end
        end

        // R6 R10 all pin patterns with varied enables
        wr(A_POL, 8'hFF);
        for (int pat = 0; pat < 256; pat++) begin
            logic [7:0] en;
            en = 8'(pat * 37 + 11);
            pins = 8'h00;
            wr(A_EN, en);
            wr(A_FLAG, 8'hFF);
            @(negedge clk);
            pins = 8'(pat);
            step(3);
            rd(A_FLAG, v0, v1);
            chk("R3 pattern flags", v0, 8'(pat));
            chk("R10 pattern flags u1", v1, 8'(pat) & 8'h0F);
            step(1);
            chk("R6 pattern irq", {7'd0, irq0}, {7'd0, |(8'(pat) & en)});
            chk("R6 pattern irq u1", {7'd0, irq1}, {7'd0, |(8'(pat) & en & 8'h0F)});
        end

        // R7 set and clear in the same cycle
        wr(A_EN, 8'h00);
        pins = 8'h00;
        step(5);
        wr(A_FLAG, 8'hFF);
        pins[0] = 1'b1;
        step(3);
        rd(A_FLAG, v0, v1); chk("R7 first flag", v0, 8'h01);
        pins[0] = 1'b0;
        step(4);
        pins[0] = 1'b1;
        step(2);
        we = 1'b1; addr = A_FLAG; wdata = 8'h01;
        @(negedge clk);
        we = 1'b0;
        rd(A_FLAG, v0, v1); chk("R7 set wins", v0, 8'h01);
        wr(A_FLAG, 8'h01);
        rd(A_FLAG, v0, v1); chk("R7 later clear", v0, 8'h00);

        // R8 polarity changes on steady pins
        pins = 8'hA5;
        step(5);
        wr(A_FLAG, 8'hFF);
        wr(A_POL, 8'h00);
        wr(A_POL, 8'hFF);
        wr(A_POL, 8'h5A);
        wr(A_POL, 8'hA5);
        step(4);
        rd(A_FLAG, v0, v1); chk("R8 no spurious flag", v0, 8'h00); chk("R8 no spurious flag u1", v1, 8'h00);

        finished = 1'b1;
        finish_run();
    end

endmodule